// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer between two clock domains. Words go in on a free-running write clock and come out on a free-running read clock. The two clocks may be unrelated, or they may be tied together. Each port is qualified by two enables that must both be active. The second write enable has a second use: while it is held low with the first write enable active, it steers the data input into the two flag threshold registers instead of the storage array.

The read side registers the word it pops into an output holding register. A separate output enable produces a drive-qualifier signal that stands in for a three-state output. The write side reports full and almost-full. The read side reports empty and almost-empty. Each flag is computed from its own local pointer and a Gray-coded copy of the far pointer that has passed through a synchronizer chain. This makes each flag conservative, never optimistic.

Top module: `dcfifo_pflags`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wen1_n` is 0, `wen2_ld` is 1 and the FIFO is not full. Words are returned in the order they were stored.
- R2: A write attempt while `full` is 1 is ignored. No word is stored and the stored contents are unchanged.
- R3: A word is popped on a rising read-clock edge only when `ren1_n` is 0, `ren2_n` is 0 and `empty` is 0. The popped word appears on `q` after that edge.
- R4: A read attempt while `empty` is 1 is ignored. `q` keeps its value and the read position does not move.
- R5: `empty` is 1 whenever the FIFO holds no word. Once both ports have been idle for 4 cycles, `empty` equals (word count == 0).
- R6: `full` is 1 whenever the FIFO holds DEPTH words. Once idle for 4 cycles, `full` equals (word count == DEPTH).
- R7: Once idle for 4 cycles, `almost_empty` equals (word count <= almost-empty offset). `empty` always implies `almost_empty`.
- R8: Once idle for 4 cycles, `almost_full` equals (DEPTH − word count <= almost-full offset). `full` always implies `almost_full`.
- R9: A write-clock edge with `wen1_n` = 0 and `wen2_ld` = 0 stores no word. Instead it loads `din[log2(DEPTH)-1:0]` into a threshold register. The first such edge after reset loads the almost-empty offset, the next loads the almost-full offset, and the two then alternate.
- R10: While `rst_n` is 0, both positions clear, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and both offsets return to 7.
- R11: `q_drive` is 1 exactly when `oe_n` is 0. `oe_n` has no effect on the value of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Write enable (high) / offset load strobe (low) |
| din | input | DW | Write data or offset value |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | DW | Registered read data |
| q_drive | output | 1 | High when q is to be driven onto a bus |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| almost_empty | output | 1 | Word count at or below almost-empty offset |
| almost_full | output | 1 | Free space at or below almost-full offset |

## Verification
The hardest state to reach from the ports is a write that arrives while the FIFO is full and that must not leave a trace. The trace can only be seen after the whole array has been drained and every word compared in order. The stimulus therefore fills the buffer to DEPTH with known words, strikes it with a distinct value, and then reads back every entry. Both threshold edges are approached one word at a time after a pair of load strobes, first with the reset offsets and then with loaded ones. A random phase then mixes all enable combinations, including the half-asserted ones, with idle windows where every flag is compared exactly.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
   // target of the next offset-load strobe
   typedef enum logic {
      LD_LOW_MARK  = 1'b0,
      LD_HIGH_MARK = 1'b1
   } ld_tgt_t;

   localparam int unsigned MIN_DEPTH = 16;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 6
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned ENTRIES = 1 << AW;

   logic [DW-1:0] mem [ENTRIES];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
   import fifo_flag_pkg::*;
#(
   parameter int unsigned DW      = 9,
   parameter int unsigned AW      = 6,
   parameter int unsigned OFF_RST = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en1_n,
   input  logic          en2_ld,
   input  logic [DW-1:0] din,
   input  logic [AW:0]   rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic [AW-1:0] lo_mark,
   output logic [AW-1:0] hi_mark,
   output logic          full,
   output logic          almost_full
);
   localparam int unsigned PW = AW + 1;
   localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};
   localparam logic [AW-1:0] MARK_RST = AW'(OFF_RST);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wbin, wbin_nx, used, space;
   ld_tgt_t       ld_tgt;
   logic          ld_go;

   assign used        = wbin - g2b(rgray_s);
   assign space       = CAP - used;
   assign full        = (used == CAP);
   assign almost_full = (space <= {1'b0, hi_mark});
   assign ld_go       = !en1_n && !en2_ld;
   assign we          = !en1_n && en2_ld && !full;
   assign wbin_nx     = wbin + 1'b1;
   assign waddr       = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         lo_mark <= MARK_RST;
         hi_mark <= MARK_RST;
         ld_tgt  <= LD_LOW_MARK;
      end else begin
         if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
         end
         if (ld_go) begin
            if (ld_tgt == LD_LOW_MARK) begin
               lo_mark <= din[AW-1:0];
               ld_tgt  <= LD_HIGH_MARK;
            end else begin
               hi_mark <= din[AW-1:0];
               ld_tgt  <= LD_LOW_MARK;
            end
         end
      end
   end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en1_n,
   input  logic          en2_n,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] lo_mark_s,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] q,
   output logic          empty,
   output logic          almost_empty
);
   localparam int unsigned PW = AW + 1;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] rbin, rbin_nx, held;
   logic          re;

   assign held         = g2b(wgray_s) - rbin;
   assign empty        = (held == '0);
   assign almost_empty = (held <= {1'b0, lo_mark_s});
   assign re           = !en1_n && !en2_n && !empty;
   assign rbin_nx      = rbin + 1'b1;
   assign raddr        = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         q     <= '0;
      end else if (re) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
         q     <= rdata;
      end
   end
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags
   import fifo_flag_pkg::*;
#(
   parameter int unsigned DW          = 9,
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFF_RST     = 7
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          wen1_n,
   input  logic          wen2_ld,
   input  logic [DW-1:0] din,
   input  logic          ren1_n,
   input  logic          ren2_n,
   input  logic          oe_n,
   output logic [DW-1:0] q,
   output logic          q_drive,
   output logic          empty,
   output logic          full,
   output logic          almost_empty,
   output logic          almost_full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (DEPTH != (1 << AW) || DEPTH < MIN_DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least MIN_DEPTH");
   end
   if (AW > DW) begin : g_bad_width
      $error("offset field must fit in the data input");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OFF_RST >= DEPTH) begin : g_bad_off
      $error("OFF_RST must be below DEPTH");
   end

   logic          we;
   logic [AW-1:0] waddr, raddr, lo_mark, hi_mark, lo_mark_s;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [DW-1:0] rdata;

   fifo_wr_ctl #(.DW(DW), .AW(AW), .OFF_RST(OFF_RST)) u_wr (
      .clk(wclk), .rst_n(rst_n), .en1_n(wen1_n), .en2_ld(wen2_ld), .din(din),
      .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
      .lo_mark(lo_mark), .hi_mark(hi_mark), .full(full), .almost_full(almost_full)
   );

   fifo_dpram #(.DW(DW), .AW(AW)) u_mem (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata)
   );

   fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   // low mark is quasi-static; it only changes on a load strobe
   fifo_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_mark (
      .clk(rclk), .rst_n(rst_n), .d(lo_mark), .q(lo_mark_s)
   );

   fifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
      .clk(rclk), .rst_n(rst_n), .en1_n(ren1_n), .en2_n(ren2_n),
      .wgray_s(wgray_s), .lo_mark_s(lo_mark_s), .rdata(rdata),
      .raddr(raddr), .rgray(rgray), .q(q),
      .empty(empty), .almost_empty(almost_empty)
   );

   assign q_drive = !oe_n;
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk #(
   parameter int unsigned DW = 9,
   parameter int unsigned PW = 7
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          wen1_n,
   input logic          wen2_ld,
   input logic          ren1_n,
   input logic          ren2_n,
   input logic [DW-1:0] q,
   input logic          empty,
   input logic          full,
   input logic          almost_empty,
   input logic          almost_full,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray
);
   AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
      (full && !wen1_n && wen2_ld) |=> $stable(wgray)); // R2

   AST_LOAD_NOT_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
      (!wen1_n && !wen2_ld) |=> $stable(wgray)); // R9

   AST_READ_ADVANCES: assert property (@(posedge rclk) disable iff (!rst_n)
      (!ren1_n && !ren2_n && !empty) |=> (rgray != $past(rgray))); // R3

   AST_EMPTY_HOLDS_Q: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty && !ren1_n && !ren2_n) |=> ($stable(q) && $stable(rgray))); // R4

   AST_EMPTY_IN_LOW: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |-> almost_empty); // R7

   AST_FULL_IN_HIGH: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> almost_full); // R8
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.DW(DW), .PW(PW)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
   .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
   .q(q), .empty(empty), .full(full),
   .almost_empty(almost_empty), .almost_full(almost_full),
   .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_pflags_tb.sv
module dcfifo_pflags_tb;
   localparam int DW = 9;
   localparam int DEPTH = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] q;
   logic q_drive, empty, full, almost_empty, almost_full;

   always #10 clk = ~clk;

   dcfifo_pflags #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .wclk(clk), .rclk(clk), .rst_n(rst_n),
      .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
      .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
      .q(q), .q_drive(q_drive), .empty(empty), .full(full),
      .almost_empty(almost_empty), .almost_full(almost_full)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   int lo_m = 7;
   int hi_m = 7;
   logic [DW-1:0] mdl[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic bit exp_low(input int n, input int m);
      return n <= m;
   endfunction

   function automatic bit exp_high(input int n, input int m);
      return (DEPTH - n) <= m;
   endfunction

   // one cycle; inputs applied at negedge, results observed at next negedge
   task automatic step(input logic w1, input logic w2, input logic [DW-1:0] d,
                       input logic r1, input logic r2);
      bit wr_ok, rd_ok;
      logic [DW-1:0] e;
      if (mdl.size() == 0) check(empty === 1'b1, "R5 empty while no word", empty, 1);
      if (mdl.size() == DEPTH) check(full === 1'b1, "R6 full at capacity", full, 1);
      wr_ok = !w1 && w2 && !full;
      rd_ok = !r1 && !r2 && !empty;
      wen1_n = w1; wen2_ld = w2; din = d; ren1_n = r1; ren2_n = r2;
      @(posedge clk);
      @(negedge clk);
      wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
      if (rd_ok) begin
         e = mdl.pop_front();
         check(q === e, "R3 R1 read order", q, e);
      end
      if (wr_ok) mdl.push_back(d);
   endtask

   task automatic wr(input logic [DW-1:0] d);
      step(1'b0, 1'b1, d, 1'b1, 1'b1);
   endtask

   task automatic rd();
      step(1'b1, 1'b1, '0, 1'b0, 1'b0);
   endtask

   task automatic settle_check();
      int n;
      repeat (4) @(negedge clk);
      n = mdl.size();
      check(empty === (n == 0), "R5 settled empty", empty, n == 0);
      check(full === (n == DEPTH), "R6 settled full", full, n == DEPTH);
      check(almost_empty === exp_low(n, lo_m), "R7 settled almost_empty",
            almost_empty, exp_low(n, lo_m));
      check(almost_full === exp_high(n, hi_m), "R8 settled almost_full",
            almost_full, exp_high(n, hi_m));
   endtask

   task automatic fill_to(input int n);
      while (mdl.size() < n) wr(DW'($urandom));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         report();
      end
   end

   initial begin
      logic [DW-1:0] hold;
      int guard;
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      // R10 reset state
      check(empty === 1'b1, "R10 reset empty", empty, 1);
      check(almost_empty === 1'b1, "R10 reset almost_empty", almost_empty, 1);
      check(full === 1'b0, "R10 reset full", full, 0);
      check(almost_full === 1'b0, "R10 reset almost_full", almost_full, 0);
      check(q_drive === 1'b0, "R11 drive off", q_drive, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 default offsets of 7 at both edges
      fill_to(7);  settle_check();
      fill_to(8);  settle_check();
      fill_to(56); settle_check();
      fill_to(57); settle_check();
      fill_to(DEPTH); settle_check();

      // R2 write while full is dropped; drain proves it
      wr(9'h1AA);
      settle_check();
      guard = 0;
      while (mdl.size() > 0 && guard < 200) begin rd(); guard++; end
      settle_check();

      // R4 read while empty: q and position hold
      hold = q;
      rd(); rd();
      check(q === hold, "R4 q holds on empty read", q, hold);
      wr(9'h0C3);
      settle_check();
      rd();
      check(q === 9'h0C3, "R4 position unchanged", q, 9'h0C3);
      settle_check();

      // R9 load strobes: low mark then high mark, no word stored
      step(1'b0, 1'b0, 9'h003, 1'b1, 1'b1);
      step(1'b0, 1'b0, 9'h005, 1'b1, 1'b1);
      lo_m = 3; hi_m = 5;
      settle_check();
      check(empty === 1'b1, "R9 load stores nothing", empty, 1);
      fill_to(3);  settle_check();
      fill_to(4);  settle_check();
      fill_to(58); settle_check();
      fill_to(59); settle_check();

      // R11 output enable only gates drive
      hold = q;
      oe_n = 1'b0; @(negedge clk);
      check(q_drive === 1'b1, "R11 drive on", q_drive, 1);
      check(q === hold, "R11 q unaffected", q, hold);
      oe_n = 1'b1; @(negedge clk);
      check(q_drive === 1'b0, "R11 drive off again", q_drive, 0);

      // random phase: all enable combinations, R1 R3 gated by both enables
      for (int i = 0; i < 4000; i++) begin
         int bias;
         logic w1, r1, r2;
         bias = (i / 500) % 2 == 0 ? 70 : 30;
         w1 = ($urandom_range(99) < bias) ? 1'b0 : 1'b1;
         r1 = ($urandom_range(99) < 100 - bias) ? 1'b0 : 1'b1;
         r2 = ($urandom_range(3) == 0) ? 1'b1 : 1'b0;
         if (w1 == 1'b0)
            step(1'b0, 1'b1, DW'($urandom), r1, r2);
         else
            step(1'b1, 1'($urandom), DW'($urandom), r1, r2);
         if (i % 100 == 99) settle_check();
      end
      settle_check();

      finished = 1;
      report();
   end
endmodule